// File: doc/BRIEF.md
# SPI Host/Client Serial Port

A byte-wide serial port for a microcontroller-style register bus. Software sets it up through a control register and, in host mode, starts an 8-bit exchange by writing the data register. The block then generates SCK from the system clock, shifts the byte out, and shifts a byte in at the same time. In client mode the same shift engine follows an external SCK and chip-select. Both are first passed through two-flop synchronisers. A completion flag, and an interrupt built from it, report the end of each byte.

Clock polarity, clock phase and bit order are selectable, so all four SPI modes work in either order. The host rate comes from a three-bit index made of a double-speed bit and two rate bits. A host whose chip-select pin is set as an input and is pulled low by another device drops back to client mode and raises the completion flag. This lets software detect a bus conflict.

Top module: `spi_periph`

## Requirements
- R1: Registers are read combinationally on `reg_rdata` from `reg_addr`. Address 0 is control: bit 0 enable, bit 1 host-select, bit 2 LSB-first, bit 3 clock polarity, bit 4 clock phase, bits 6:5 rate, bit 7 local interrupt enable. Address 1 is status: bit 0 double-speed (writable), bit 7 completion flag (read-only). Address 2 is data. After reset every register reads 0, `irq` is 0 and no output enable is active.
- R2: With the enable bit 0, nothing happens on the serial side: a data write drives no SCK edge, `sck_oe`, `mosi_oe` and `miso_oe` stay 0, and the flag stays 0.
- R3: With LSB-first set, bit 0 of the byte is the first bit on the line; with it clear, bit 7 is first. This applies to both the sent and the received byte.
- R4: With polarity 0, SCK idles low and the leading edge rises. With polarity 1, SCK idles high and the leading edge falls. A host returns SCK to the idle level after each byte.
- R5: With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R6: A host byte has exactly 16 SCK edges spaced divisor/2 system clocks apart. The divisor is indexed by {double-speed, rate[1], rate[0]}: 000→4, 001→16, 010→64, 011→128, 100→2, 101→8, 110→32, 111→64.
- R7: In host mode, a data write while enabled and idle starts a byte. The flag is set once the eighth bit is sampled, and a data read then returns the byte received on `miso_in`.
- R8: In client mode the block shifts on the external `sck_in`, with `mosi_in` as input and `miso_out` as output. The rate bits have no effect. `miso_oe` is 1 only while `ss_n_in` is low.
- R9: While `ss_n_in` is high in client mode, the bit counter is held at zero, so a byte broken off part way leaves no residue. A fresh data write is accepted and the next byte is exact.
- R10: If host mode is on, `ss_is_input` is 1 and `ss_n_in` goes low, then host-select clears, the flag sets and `sck_oe` drops. A low `ss_n_in` with `ss_is_input` 0 has no effect.
- R11: After such a fault, host mode stays off until software writes host-select to 1 again. A write made while `ss_n_in` is still low is overridden, and the block stays in client mode.
- R12: `irq` is 1 exactly when the flag, the local interrupt enable and `glob_ie` are all 1.
- R13: The flag clears only on a data-register access that follows a status read which saw the flag set. A data access without that prior status read leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| glob_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | External serial clock (client) |
| sck_out | output | 1 | Generated serial clock (host) |
| sck_oe | output | 1 | Drive enable for SCK |
| mosi_in | input | 1 | Host-to-client data in (client) |
| mosi_out | output | 1 | Host-to-client data out (host) |
| mosi_oe | output | 1 | Drive enable for MOSI |
| miso_in | input | 1 | Client-to-host data in (host) |
| miso_out | output | 1 | Client-to-host data out (client) |
| miso_oe | output | 1 | Drive enable for MISO |
| ss_n_in | input | 1 | Chip-select pin level, active low |
| ss_is_input | input | 1 | 1 when the chip-select pin is set as an input |

## Verification
Two writers of the host-select bit can act on the same cycle: a software write to the control register, and the mode-fault clear raised by a low chip-select. The bench provokes this by holding `ss_n_in` low and writing host-select to 1. It then reads the control register a few cycles later and requires the bit to be 0 and the flag to be 1. After `ss_n_in` is released, the same write must stick. The bench also plays the remote end of every link. It samples and drives data on the edges that its own reading of polarity and phase calls for, so any disagreement in edge meaning or bit order shows up as a wrong byte.

// File: rtl/spi_periph_pkg.sv
package spi_periph_pkg;

  localparam int REG_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic       irq_en;
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       lsb_first;
    logic       host;
    logic       en;
  } ctrl_t;

  // log2 of the half period in system clocks, index {dbl, rate}
  function automatic logic [2:0] half_log2(input logic [2:0] sel);
    logic [2:0] base;
    case (sel[1:0])
      2'd0:    base = 3'd2;
      2'd1:    base = 3'd4;
      2'd2:    base = 3'd6;
      default: base = 3'd7;
    endcase
    return base - {2'b00, sel[2]} - 3'd1;
  endfunction

endpackage

// File: rtl/spi_sync2.sv
module spi_sync2 #(
  parameter int                W       = 1,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen import spi_periph_pkg::*; #(
  parameter int CNT_W  = 7,
  parameter int EDGES  = 16,
  localparam int EDGE_W = $clog2(EDGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cpol,
  input  logic [2:0]        rate_sel,
  output logic              sck,
  output logic              tick,
  output logic              lead,
  output logic [EDGE_W-1:0] edge_idx
);

  logic [CNT_W-1:0]  cnt_q, cnt_d, reload;
  logic              phase_q, phase_d;
  logic [EDGE_W-1:0] edge_q, edge_d;

  assign reload = (CNT_W'(1) << half_log2(rate_sel)) - CNT_W'(1);

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    edge_d  = edge_q;
    tick    = 1'b0;
    if (!run) begin
      cnt_d   = reload;
      phase_d = 1'b0;
      edge_d  = '0;
    end else if (cnt_q == '0) begin
      tick    = 1'b1;
      cnt_d   = reload;
      phase_d = ~phase_q;
      edge_d  = edge_q + EDGE_W'(1);
    end else begin
      cnt_d   = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      edge_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      edge_q  <= edge_d;
    end
  end

  assign sck      = cpol ^ (phase_q & run);
  assign lead     = ~phase_q;
  assign edge_idx = edge_q;

  AST_EDGES_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (edge_q == '0 && !phase_q)); // R6

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         lsb_first,
  input  logic         sample,
  input  logic         setup,
  input  logic         in_bit,
  input  logic         clear,
  output logic         out_bit,
  output logic [W-1:0] data,
  output logic         done,
  output logic         idle
);

  logic [W-1:0]  sreg_q, sreg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;
  logic          head, load_head;

  assign head      = lsb_first ? sreg_q[0]    : sreg_q[W-1];
  assign load_head = lsb_first ? load_data[0] : load_data[W-1];

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    out_d  = out_q;
    done   = 1'b0;
    if (load) begin
      sreg_d = load_data;
      cnt_d  = '0;
      out_d  = load_head;
    end else if (clear) begin
      cnt_d  = '0;
      out_d  = head;
    end else begin
      if (sample) begin
        sreg_d = lsb_first ? {in_bit, sreg_q[W-1:1]} : {sreg_q[W-2:0], in_bit};
        if (cnt_q == CW'(W-1)) begin
          cnt_d = '0;
          done  = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      if (setup) begin
        out_d = head;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      out_q  <= out_d;
    end
  end

  assign out_bit = out_q;
  assign data    = sreg_q;
  assign idle    = (cnt_q == '0);

  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> idle); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

endmodule

// File: rtl/spi_periph.sv
module spi_periph import spi_periph_pkg::*; #(
  parameter int DIV_CNT_W = 7,
  parameter int XFER_W    = REG_W,
  localparam int EDGES    = 2 * XFER_W,
  localparam int EDGE_W   = $clog2(EDGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             glob_ie,
  output logic             irq,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  input  logic             mosi_in,
  output logic             mosi_out,
  output logic             mosi_oe,
  input  logic             miso_in,
  output logic             miso_out,
  output logic             miso_oe,
  input  logic             ss_n_in,
  input  logic             ss_is_input
);

  ctrl_t ctrl_q, ctrl_d;
  logic  dbl_q, dbl_d;
  logic  flag_q, flag_d;
  logic  arm_q, arm_d;
  logic  busy_q, busy_d;
  logic  sck_prev_q;

  logic [2:0] pins_s;
  logic       sck_s, mosi_s, ss_s;

  logic              host_mode, client_sel, fault;
  logic              gen_sck, gen_tick, gen_lead;
  logic [EDGE_W-1:0] gen_edge;
  logic              edge_ev, lead_ev, is_sample;
  logic              sh_sample, sh_setup, sh_in, sh_clear, sh_load;
  logic              sh_out, sh_done, sh_idle;
  logic [XFER_W-1:0] sh_data;
  logic              wr_ctrl, wr_stat, wr_data, rd_stat, acc_data, start;
  logic              unused_wbits;

  // ---------------- pin synchronisers ----------------
  spi_sync2 #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck_in, mosi_in, ss_n_in}),
    .q     (pins_s)
  );
  assign sck_s  = pins_s[2];
  assign mosi_s = pins_s[1];
  assign ss_s   = pins_s[0];

  // ---------------- decode ----------------
  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_data  = reg_wr && (reg_addr == ADDR_DATA);
  assign rd_stat  = reg_rd && (reg_addr == ADDR_STAT);
  assign acc_data = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
  assign unused_wbits = ^reg_wdata[REG_W-1:1];

  assign host_mode  = ctrl_q.en && ctrl_q.host;
  assign client_sel = ctrl_q.en && !ctrl_q.host && !ss_s;
  assign fault      = host_mode && ss_is_input && !ss_s;
  assign start      = wr_data && host_mode && !busy_q && sh_idle;

  // ---------------- host clock ----------------
  spi_sck_gen #(.CNT_W(DIV_CNT_W), .EDGES(EDGES)) u_sck_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .cpol     (ctrl_q.cpol),
    .rate_sel ({dbl_q, ctrl_q.rate}),
    .sck      (gen_sck),
    .tick     (gen_tick),
    .lead     (gen_lead),
    .edge_idx (gen_edge)
  );

  // ---------------- edge classification ----------------
  always_comb begin
    if (host_mode) begin
      edge_ev = gen_tick;
      lead_ev = gen_lead;
      sh_in   = miso_in;
    end else begin
      edge_ev = client_sel && (sck_s != sck_prev_q);
      lead_ev = sck_s ^ ctrl_q.cpol;
      sh_in   = mosi_s;
    end
    is_sample = lead_ev ^ ctrl_q.cpha;
  end

  assign sh_sample = edge_ev && is_sample;
  assign sh_setup  = edge_ev && !is_sample;
  assign sh_clear  = !host_mode && (ss_s || !ctrl_q.en);
  assign sh_load   = wr_data && !busy_q && sh_idle;

  spi_shift_unit #(.W(XFER_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sh_load),
    .load_data (reg_wdata),
    .lsb_first (ctrl_q.lsb_first),
    .sample    (sh_sample),
    .setup     (sh_setup),
    .in_bit    (sh_in),
    .clear     (sh_clear),
    .out_bit   (sh_out),
    .data      (sh_data),
    .done      (sh_done),
    .idle      (sh_idle)
  );

  // ---------------- next state ----------------
  always_comb begin
    ctrl_d = ctrl_q;
    dbl_d  = dbl_q;
    flag_d = flag_q;
    arm_d  = arm_q;
    busy_d = busy_q;

    if (wr_ctrl) ctrl_d = ctrl_t'(reg_wdata);
    if (wr_stat) dbl_d  = reg_wdata[0];
    // mode fault is applied after the software write so it wins
    if (fault)   ctrl_d.host = 1'b0;

    if (!host_mode || fault) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
    end else if (gen_tick && gen_edge == EDGE_W'(EDGES-1)) begin
      busy_d = 1'b0;
    end

    if (rd_stat && flag_q) arm_d = 1'b1;
    if (acc_data && arm_q) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end
    if (sh_done || fault) flag_d = 1'b1;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      dbl_q      <= 1'b0;
      flag_q     <= 1'b0;
      arm_q      <= 1'b0;
      busy_q     <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      dbl_q      <= dbl_d;
      flag_q     <= flag_d;
      arm_q      <= arm_d;
      busy_q     <= busy_d;
      sck_prev_q <= sck_s;
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl_q;
      ADDR_STAT: reg_rdata = {flag_q, {(REG_W-2){1'b0}}, dbl_q};
      ADDR_DATA: reg_rdata = sh_data;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq      = flag_q && ctrl_q.irq_en && glob_ie;
  assign sck_out  = host_mode ? gen_sck : ctrl_q.cpol;
  assign sck_oe   = host_mode;
  assign mosi_out = sh_out;
  assign mosi_oe  = host_mode;
  assign miso_out = sh_out;
  assign miso_oe  = client_sel;

  // ---------------- assertions ----------------
  AST_OFF_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |=> !busy_q); // R2
  AST_IDLE_SCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && !busy_q) |-> (sck_out == ctrl_q.cpol)); // R4
  AST_FAULT_DROPS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!ctrl_q.host && flag_q)); // R10
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sh_done |=> flag_q); // R7

endmodule

// File: tb/spi_periph_tb.sv
module spi_periph_tb;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic       clk, rst_n;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       glob_ie, irq;
  logic       sck_in, sck_out, sck_oe;
  logic       mosi_in, mosi_out, mosi_oe;
  logic       miso_in, miso_out, miso_oe;
  logic       ss_n_in, ss_is_input;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  spi_periph u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .glob_ie(glob_ie), .irq(irq),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
    .ss_n_in(ss_n_in), .ss_is_input(ss_is_input)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic ie, input logic [1:0] rate, input logic cpha,
                                    input logic cpol, input logic lsb, input logic host, input logic en);
    return {ie, rate, cpha, cpol, lsb, host, en};
  endfunction

  function automatic int bp(input int k, input logic lsb);
    return lsb ? k : 7 - k;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [7:0] v;
    rd(A_CTRL, v); chk("R1", "ctrl after reset", v, 0);
    rd(A_STAT, v); chk("R1", "status after reset", v, 0);
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "enables after reset", {sck_oe, mosi_oe, miso_oe}, 0);
  endtask

  task automatic test_disabled();
    logic [7:0] v;
    int moved = 0;
    wr(A_CTRL, mk(0, 2'd0, 0, 0, 0, 1, 0));
    wr(A_DATA, 8'hA5);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sck_out !== 1'b0 || sck_oe || mosi_oe || miso_oe) moved++;
    end
    chk("R2", "serial activity while disabled", moved, 0);
    rd(A_STAT, v); chk("R2", "flag while disabled", v[7], 0);
  endtask

  task automatic host_xfer(input string tag, input logic cpol, input logic cpha, input logic lsb,
                           input logic dbl, input logic [1:0] rate,
                           input logic [7:0] tx, input logic [7:0] ptx, input int half);
    logic [7:0] prx, v;
    logic prev, lead, smp;
    int edges, oidx, sidx, cyc, t1, t2;
    wr(A_STAT, {7'd0, dbl});
    wr(A_CTRL, mk(0, rate, cpha, cpol, lsb, 1, 1));
    prx = 8'h00; t1 = 0; t2 = 0;
    miso_in = ptx[bp(0, lsb)];
    oidx = cpha ? 0 : 1; sidx = 0;
    chk("R4", {tag, " idle level"}, sck_out, cpol);
    wr(A_DATA, tx);
    prev = sck_out; edges = 0; cyc = 0;
    while (edges < 16 && cyc < 5000) begin
      @(negedge clk); cyc++;
      if (sck_out !== prev) begin
        prev = sck_out; edges++;
        if (edges == 1) t1 = cyc;
        if (edges == 2) t2 = cyc;
        lead = (sck_out !== cpol);
        smp  = lead ^ cpha;
        if (smp) begin
          prx[bp(sidx, lsb)] = mosi_out; sidx++;
        end else begin
          if (oidx < 8) miso_in = ptx[bp(oidx, lsb)];
          oidx++;
        end
      end
    end
    idle(4);
    chk("R6", {tag, " edge count"}, edges, 16);
    chk("R6", {tag, " half period"}, t2 - t1, half);
    chk("R4", {tag, " level after byte"}, sck_out, cpol);
    chk("R3", {tag, " byte seen on mosi"}, prx, tx);
    rd(A_STAT, v); chk("R7", {tag, " flag"}, v[7], 1);
    rd(A_DATA, v); chk("R5", {tag, " byte received"}, v, ptx);
  endtask

  task automatic client_xfer(input string tag, input logic cpol, input logic cpha, input logic lsb,
                             input logic [1:0] rate, input logic [7:0] tx, input logic [7:0] btx,
                             input int abort_edges);
    logic [7:0] brx, v;
    logic lead, smp;
    int oidx, sidx;
    ss_n_in = 1'b1; sck_in = cpol;
    wr(A_CTRL, mk(0, rate, cpha, cpol, lsb, 0, 1));
    idle(4);
    wr(A_DATA, tx);
    if (abort_edges > 0) begin
      ss_n_in = 1'b0; idle(6);
      for (int e = 0; e < abort_edges; e++) begin
        sck_in = ~sck_in; mosi_in = ~mosi_in; idle(6);
      end
      ss_n_in = 1'b1; idle(6);
      sck_in = cpol; idle(6);
      chk("R8", {tag, " miso released while deselected"}, miso_oe, 0);
      wr(A_DATA, tx);
    end
    brx = 8'h00;
    mosi_in = btx[bp(0, lsb)];
    oidx = cpha ? 0 : 1; sidx = 0;
    ss_n_in = 1'b0; idle(6);
    chk("R8", {tag, " miso driven when selected"}, miso_oe, 1);
    for (int e = 0; e < 16; e++) begin
      lead = (e % 2 == 0);
      smp  = lead ^ cpha;
      if (smp) begin
        brx[bp(sidx, lsb)] = miso_out; sidx++;
      end
      sck_in = ~sck_in;
      if (!smp) begin
        if (oidx < 8) mosi_in = btx[bp(oidx, lsb)];
        oidx++;
      end
      idle(6);
    end
    ss_n_in = 1'b1; idle(5);
    chk("R8", {tag, " miso off after deselect"}, miso_oe, 0);
    chk(abort_edges > 0 ? "R9" : "R3", {tag, " byte seen on miso"}, brx, tx);
    rd(A_STAT, v); chk("R8", {tag, " flag"}, v[7], 1);
    rd(A_DATA, v); chk("R5", {tag, " byte received"}, v, btx);
  endtask

  task automatic test_fault();
    logic [7:0] v;
    ss_is_input = 1'b1; ss_n_in = 1'b1;
    wr(A_CTRL, mk(0, 2'd0, 0, 0, 0, 1, 1));
    idle(4);
    rd(A_CTRL, v); chk("R10", "host set before fault", v[1], 1);
    ss_n_in = 1'b0; idle(6);
    rd(A_CTRL, v); chk("R10", "host cleared by fault", v[1], 0);
    chk("R10", "sck_oe after fault", sck_oe, 0);
    rd(A_STAT, v); chk("R10", "flag after fault", v[7], 1);
    rd(A_DATA, v);
    wr(A_CTRL, mk(0, 2'd0, 0, 0, 0, 1, 1));
    idle(6);
    rd(A_CTRL, v); chk("R11", "rewrite during fault overridden", v[1], 0);
    ss_n_in = 1'b1; idle(4);
    rd(A_CTRL, v); chk("R11", "stays client until rewrite", v[1], 0);
    wr(A_CTRL, mk(0, 2'd0, 0, 0, 0, 1, 1));
    idle(4);
    rd(A_CTRL, v); chk("R11", "rewrite after release holds", v[1], 1);
    ss_is_input = 1'b0; ss_n_in = 1'b0; idle(6);
    rd(A_CTRL, v); chk("R10", "output-configured pin ignored", v[1], 1);
    ss_n_in = 1'b1; ss_is_input = 1'b1; idle(4);
    rd(A_STAT, v); rd(A_DATA, v);
    rd(A_STAT, v); chk("R13", "flag cleared by status then data", v[7], 0);
  endtask

  task automatic test_irq_and_clear();
    logic [7:0] v;
    ss_n_in = 1'b1; ss_is_input = 1'b1;
    wr(A_CTRL, mk(0, 2'd0, 0, 0, 0, 1, 1));
    idle(3);
    ss_n_in = 1'b0; idle(6);
    ss_n_in = 1'b1; idle(4);
    for (int c = 0; c < 4; c++) begin
      glob_ie = c[1];
      wr(A_CTRL, mk(c[0], 2'd0, 0, 0, 0, 0, 1));
      idle(1);
      chk("R12", $sformatf("irq combo %0d", c), irq, (c == 3) ? 1 : 0);
    end
    rd(A_DATA, v); idle(1);
    chk("R13", "flag kept by bare data read", irq, 1);
    rd(A_STAT, v);
    chk("R13", "flag visible in status", v[7], 1);
    rd(A_DATA, v); idle(1);
    chk("R13", "irq drops after clear sequence", irq, 0);
    glob_ie = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    glob_ie = 1'b0; sck_in = 1'b0; mosi_in = 1'b0; miso_in = 1'b0;
    ss_n_in = 1'b1; ss_is_input = 1'b1;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    test_reset();
    test_disabled();
    host_xfer("host m0 div4",   0, 0, 0, 0, 2'd0, 8'hB4, 8'h3C, 2);
    host_xfer("host m3 div8",   1, 1, 1, 1, 2'd1, 8'h81, 8'h6E, 4);
    host_xfer("host m1 div128", 0, 1, 0, 0, 2'd3, 8'h1F, 8'hC2, 64);
    host_xfer("host m2 div2",   1, 0, 1, 1, 2'd0, 8'h5A, 8'h97, 1);
    host_xfer("host m0 div64",  0, 0, 1, 1, 2'd3, 8'hE3, 8'h04, 32);
    host_xfer("host m3 div32",  1, 1, 0, 1, 2'd2, 8'h29, 8'hF1, 16);
    client_xfer("client m0",         0, 0, 0, 2'd0, 8'hC5, 8'h3A, 0);
    client_xfer("client m3 rate11",  1, 1, 1, 2'd3, 8'h8E, 8'h71, 0);
    client_xfer("client m2",         1, 0, 0, 2'd2, 8'h0F, 8'hD2, 0);
    client_xfer("client abort",      0, 1, 1, 2'd1, 8'h96, 8'h4B, 5);
    test_fault();
    test_irq_and_clear();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule